// File: doc/BRIEF.md
# Banked Peripheral Reset Controller

This block owns the module-reset lines of a subsystem. The lines are grouped into five 32-bit reset banks: processor, peripheral group 0, peripheral group 1, bridge and system. A bit at 1 holds the matching module in reset, and a bit at 0 releases it. Each bank output is a register, so downstream reset synchronisers see lines that do not glitch.

Software-side logic drives the block with single-cycle command strobes. A line command names a bank, a bit index and a set/clear flag. Two dedicated strobes hold or release the peripheral watchdog. A mass-reset strobe starts a fixed sequence that takes two clock cycles. The first step puts every group-1 peripheral in reset except the watchdog and the system timer. In the same step it sets every group-0 line except the ECC lines. The second step then sets the group-0 ECC lines, and a completion pulse marks the end of the sequence.

Top module: `bank_reset_ctrl`

## Requirements
- R1: Bank code 0 addresses the processor bank, 1 peripheral group 0, 2 peripheral group 1, 3 the bridge bank and 4 the system bank.
- R2: A line command with bank code 5, 6 or 7 changes no register.
- R3: A line command with `cmd_set`=1 sets bit `cmd_bit` of the addressed bank on the next clock edge. All other bits in all banks are left unchanged.
- R4: A line command with `cmd_set`=0 clears bit `cmd_bit` of the addressed bank on the next clock edge. All other bits are left unchanged. Bit index 31 is valid.
- R5: An accepted `mass_start` loads peripheral group 1 on the next edge. Every bit becomes 1 except bit `WD_BIT` (default 5) and bit `TMR_BIT` (default 9), which become 0.
- R6: On that same edge, every group-0 bit outside `ECC_MASK` (default 32'h00FF_0000) becomes 1. The group-0 bits inside `ECC_MASK` keep their value.
- R7: On the edge that follows step one, the `ECC_MASK` bits of group 0 become 1. At the same time `mass_done_o` rises for exactly one cycle.
- R8: `wd_hold` sets group-1 bit `WD_BIT`, and `wd_release` clears it. If both are strobed together, hold wins. Both override a line command to that same bit in the same cycle.
- R9: After `rst_n` is low, each bank reads the inverse of its `RELEASE_INIT` slice. With the defaults this gives processor 32'hFFFF_FFFE, system 32'hFFFF_FFF0 and all other banks 32'hFFFF_FFFF.
- R10: In the cycle of an accepted `mass_start` and in the cycle after it, line commands, watchdog strobes and a repeated `mass_start` are ignored. The processor, bridge and system banks are never changed by the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Line command strobe |
| cmd_bank | input | 3 | Bank code of the line command |
| cmd_bit | input | 5 | Bit index of the line command |
| cmd_set | input | 1 | 1 sets the line, 0 clears it |
| wd_hold | input | 1 | Put the watchdog into reset |
| wd_release | input | 1 | Release the watchdog from reset |
| mass_start | input | 1 | Start the mass-reset sequence |
| rst_mpu_o | output | 32 | Processor reset bank |
| rst_per0_o | output | 32 | Peripheral group 0 reset bank |
| rst_per1_o | output | 32 | Peripheral group 1 reset bank |
| rst_brg_o | output | 32 | Bridge reset bank |
| rst_sys_o | output | 32 | System reset bank |
| mass_done_o | output | 1 | One-cycle pulse at the end of the mass sequence |

## Verification
On every cycle the assertions check the following:
- A bad bank code leaves all five banks frozen.
- Line commands to the bridge and system banks hit the addressed bit.
- The step-one image of group 1 is correct.
- The group-0 ECC bits survive step one.
- Group 0 reads all ones and the pulse is single when the sequence completes.
- The watchdog strobes act on their bit.
- The banks outside the sequence stay stable while it runs.

Only the scenarios of the bench can show some other behaviours. These are the exact bit image of every bank after mixed command histories, the reset values, the priority between the watchdog strobes and a colliding line command, and the rejection of commands and of a second start that arrive while the sequence is running.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    localparam int NBANK = 5;

    typedef enum logic [2:0] {
        BK_MPU  = 3'd0,
        BK_PER0 = 3'd1,
        BK_PER1 = 3'd2,
        BK_BRG  = 3'd3,
        BK_SYS  = 3'd4
    } bank_e;
endpackage

// File: rtl/rstc_decode.sv
module rstc_decode
    import rstc_pkg::*;
#(
    parameter int DW = 32,
    parameter int BW = $clog2(DW)
) (
    input  logic                       valid,
    input  logic [2:0]                 bank,
    input  logic [BW-1:0]              bit_idx,
    input  logic                       set_flag,
    output logic [NBANK-1:0][DW-1:0]   set_m,
    output logic [NBANK-1:0][DW-1:0]   clr_m
);
    logic [DW-1:0] one_hot;

    always_comb begin
        one_hot = '0;
        one_hot[bit_idx] = 1'b1;
        set_m = '0;
        clr_m = '0;
        for (int i = 0; i < NBANK; i++) begin
            if (valid && bank == 3'(i)) begin
                if (set_flag) set_m[i] = one_hot;
                else          clr_m[i] = one_hot;
            end
        end
    end
endmodule

// File: rtl/rstc_mass_seq.sv
module rstc_mass_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic step1,
    output logic step2,
    output logic busy,
    output logic done
);
    typedef struct packed {
        logic busy;
        logic done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        step1      = start && !seq_q.busy;
        step2      = seq_q.busy;
        seq_d.busy = step1;
        seq_d.done = step2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy = seq_q.busy;
    assign done = seq_q.done;
endmodule

// File: rtl/rstc_bank.sv
module rstc_bank #(
    parameter int            DW   = 32,
    parameter logic [DW-1:0] INIT = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [DW-1:0] load_val,
    input  logic [DW-1:0] set_m,
    input  logic [DW-1:0] clr_m,
    output logic [DW-1:0] q
);
    logic [DW-1:0] q_d, q_q;

    always_comb begin
        if (load_en) q_d = load_val;
        else         q_d = (q_q & ~clr_m) | set_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= INIT;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/bank_reset_ctrl.sv
module bank_reset_ctrl
    import rstc_pkg::*;
#(
    parameter int                  DW           = 32,
    parameter int                  WD_BIT       = 5,
    parameter int                  TMR_BIT      = 9,
    parameter logic [DW-1:0]       ECC_MASK     = 32'h00FF_0000,
    parameter logic [5*DW-1:0]     RELEASE_INIT = {32'h0000_000F, 32'h0, 32'h0, 32'h0, 32'h0000_0001}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_bank,
    input  logic [4:0]    cmd_bit,
    input  logic          cmd_set,
    input  logic          wd_hold,
    input  logic          wd_release,
    input  logic          mass_start,
    output logic [DW-1:0] rst_mpu_o,
    output logic [DW-1:0] rst_per0_o,
    output logic [DW-1:0] rst_per1_o,
    output logic [DW-1:0] rst_brg_o,
    output logic [DW-1:0] rst_sys_o,
    output logic          mass_done_o
);
    localparam int            BW         = $clog2(DW);
    localparam logic [DW-1:0] SPARE_MASK = (DW'(1) << WD_BIT) | (DW'(1) << TMR_BIT);
    localparam logic [DW-1:0] WD_MASK    = DW'(1) << WD_BIT;

    typedef struct packed {
        logic [NBANK-1:0][DW-1:0] set_m;
        logic [NBANK-1:0][DW-1:0] clr_m;
        logic [NBANK-1:0]         load_en;
        logic [NBANK-1:0][DW-1:0] load_val;
    } ctl_t;

    logic                     seq_step1, seq_step2, seq_busy, seq_done;
    logic                     blocked;
    logic [NBANK-1:0][DW-1:0] dec_set, dec_clr;
    logic [NBANK-1:0][DW-1:0] bank_q;
    ctl_t                     ctl_d;

    rstc_mass_seq i_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mass_start),
        .step1 (seq_step1),
        .step2 (seq_step2),
        .busy  (seq_busy),
        .done  (seq_done)
    );

    assign blocked = mass_start || seq_busy;

    rstc_decode #(.DW(DW), .BW(BW)) i_dec (
        .valid    (cmd_valid && !blocked),
        .bank     (cmd_bank),
        .bit_idx  (BW'(cmd_bit)),
        .set_flag (cmd_set),
        .set_m    (dec_set),
        .clr_m    (dec_clr)
    );

    always_comb begin
        ctl_d          = '0;
        ctl_d.set_m    = dec_set;
        ctl_d.clr_m    = dec_clr;
        // watchdog strobes override a line command on the same bit
        if (!blocked && wd_hold) begin
            ctl_d.set_m[BK_PER1] = ctl_d.set_m[BK_PER1] | WD_MASK;
            ctl_d.clr_m[BK_PER1] = ctl_d.clr_m[BK_PER1] & ~WD_MASK;
        end else if (!blocked && wd_release) begin
            ctl_d.set_m[BK_PER1] = ctl_d.set_m[BK_PER1] & ~WD_MASK;
            ctl_d.clr_m[BK_PER1] = ctl_d.clr_m[BK_PER1] | WD_MASK;
        end
        // step one: full image for group 1, non-ECC lines of group 0
        if (seq_step1) begin
            ctl_d.load_en[BK_PER1]  = 1'b1;
            ctl_d.load_val[BK_PER1] = ~SPARE_MASK;
            ctl_d.set_m[BK_PER0]    = ~ECC_MASK;
            ctl_d.clr_m[BK_PER0]    = '0;
        end
        // step two: ECC lines of group 0 last
        if (seq_step2) begin
            ctl_d.set_m[BK_PER0] = ECC_MASK;
            ctl_d.clr_m[BK_PER0] = '0;
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        rstc_bank #(
            .DW   (DW),
            .INIT (~RELEASE_INIT[g*DW +: DW])
        ) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (ctl_d.load_en[g]),
            .load_val (ctl_d.load_val[g]),
            .set_m    (ctl_d.set_m[g]),
            .clr_m    (ctl_d.clr_m[g]),
            .q        (bank_q[g])
        );
    end

    assign rst_mpu_o   = bank_q[BK_MPU];
    assign rst_per0_o  = bank_q[BK_PER0];
    assign rst_per1_o  = bank_q[BK_PER1];
    assign rst_brg_o   = bank_q[BK_BRG];
    assign rst_sys_o   = bank_q[BK_SYS];
    assign mass_done_o = seq_done;
endmodule

// File: rtl/rstc_chk.sv
module rstc_chk #(
    parameter int            DW       = 32,
    parameter int            WD_BIT   = 5,
    parameter int            TMR_BIT  = 9,
    parameter logic [DW-1:0] ECC_MASK = 32'h00FF_0000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [2:0]    cmd_bank,
    input logic [4:0]    cmd_bit,
    input logic          cmd_set,
    input logic          wd_hold,
    input logic          wd_release,
    input logic          mass_start,
    input logic          busy,
    input logic [DW-1:0] rst_mpu_o,
    input logic [DW-1:0] rst_per0_o,
    input logic [DW-1:0] rst_per1_o,
    input logic [DW-1:0] rst_brg_o,
    input logic [DW-1:0] rst_sys_o,
    input logic          mass_done_o
);
    logic free_cyc;
    assign free_cyc = !mass_start && !busy && !wd_hold && !wd_release;

    // R2
    bad_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_bank > 3'd4 && free_cyc |=>
        $stable(rst_mpu_o) && $stable(rst_per0_o) && $stable(rst_per1_o) &&
        $stable(rst_brg_o) && $stable(rst_sys_o));

    // R3
    set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_bank == 3'd3 && cmd_set && free_cyc |=>
        rst_brg_o[$past(cmd_bit)]);

    // R4
    clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_bank == 3'd4 && !cmd_set && free_cyc |=>
        !rst_sys_o[$past(cmd_bit)]);

    // R5
    step1_per1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mass_start && !busy |=>
        rst_per1_o == ~((DW'(1) << WD_BIT) | (DW'(1) << TMR_BIT)));

    // R6
    step1_ecc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mass_start && !busy |=>
        ((rst_per0_o | ECC_MASK) == {DW{1'b1}}) &&
        ((rst_per0_o & ECC_MASK) == ($past(rst_per0_o) & ECC_MASK)));

    // R7
    done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mass_done_o |-> rst_per0_o == {DW{1'b1}});

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mass_start && !busy |=> !mass_done_o ##1 mass_done_o ##1 !mass_done_o);

    // R8
    wd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_hold && !mass_start && !busy |=> rst_per1_o[WD_BIT]);

    // R8
    wd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_release && !wd_hold && !mass_start && !busy |=> !rst_per1_o[WD_BIT]);

    // R10
    seq_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mass_start || busy |=>
        $stable(rst_mpu_o) && $stable(rst_brg_o) && $stable(rst_sys_o));
endmodule

bind bank_reset_ctrl rstc_chk #(
    .DW(DW), .WD_BIT(WD_BIT), .TMR_BIT(TMR_BIT), .ECC_MASK(ECC_MASK)
) i_rstc_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_bank(cmd_bank),
    .cmd_bit(cmd_bit), .cmd_set(cmd_set), .wd_hold(wd_hold),
    .wd_release(wd_release), .mass_start(mass_start), .busy(seq_busy),
    .rst_mpu_o(rst_mpu_o), .rst_per0_o(rst_per0_o), .rst_per1_o(rst_per1_o),
    .rst_brg_o(rst_brg_o), .rst_sys_o(rst_sys_o), .mass_done_o(mass_done_o)
);

// File: tb/test_bank_reset_ctrl.sv
module test_bank_reset_ctrl;
    localparam int          WD   = 5;
    localparam int          TMR  = 9;
    localparam logic [31:0] ECC  = 32'h00FF_0000;
    localparam logic [31:0] SPARE = (32'd1 << WD) | (32'd1 << TMR);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_set = 1'b0, wd_hold = 1'b0, wd_release = 1'b0, mass_start = 1'b0;
    logic [2:0] cmd_bank = '0;
    logic [4:0] cmd_bit = '0;
    logic [31:0] rst_mpu_o, rst_per0_o, rst_per1_o, rst_brg_o, rst_sys_o;
    logic mass_done_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bank_reset_ctrl i_bank_reset_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_bank(cmd_bank),
        .cmd_bit(cmd_bit), .cmd_set(cmd_set), .wd_hold(wd_hold),
        .wd_release(wd_release), .mass_start(mass_start),
        .rst_mpu_o(rst_mpu_o), .rst_per0_o(rst_per0_o), .rst_per1_o(rst_per1_o),
        .rst_brg_o(rst_brg_o), .rst_sys_o(rst_sys_o), .mass_done_o(mass_done_o)
    );

    // scoreboard state
    logic [160:0] exp_q[$];
    string        tag_q[$];
    logic [31:0]  mr[5];
    logic         mbusy;

    function automatic logic [160:0] snap();
        return {rst_sys_o, rst_brg_o, rst_per1_o, rst_per0_o, rst_mpu_o, mass_done_o};
    endfunction

    task automatic compare(input logic [160:0] act, input logic [160:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic tick(input logic v, input logic [2:0] b, input logic [4:0] bi,
                        input logic s, input logic h, input logic r,
                        input logic st, input string tag);
        logic [31:0] nr[5];
        logic blk, ndone, nbusy;
        @(negedge clk);
        cmd_valid = v; cmd_bank = b; cmd_bit = bi; cmd_set = s;
        wd_hold = h; wd_release = r; mass_start = st;
        nr = mr;
        blk = st || mbusy;
        ndone = mbusy;
        nbusy = st && !mbusy;
        if (!blk) begin
            if (v && b < 3'd5) nr[b][bi] = s;
            if (h)      nr[2][WD] = 1'b1;
            else if (r) nr[2][WD] = 1'b0;
        end
        if (st && !mbusy) begin
            nr[2] = ~SPARE;
            nr[1] = nr[1] | ~ECC;
        end
        if (mbusy) nr[1] = nr[1] | ECC;
        exp_q.push_back({nr[4], nr[3], nr[2], nr[1], nr[0], ndone});
        tag_q.push_back(tag);
        mr = nr;
        mbusy = nbusy;
    endtask

    task automatic idle(input string tag);
        tick(1'b0, 3'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // monitor
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) compare(snap(), exp_q.pop_front(), tag_q.pop_front());
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        mr[0] = 32'hFFFF_FFFE; mr[1] = '1; mr[2] = '1; mr[3] = '1; mr[4] = 32'hFFFF_FFF0;
        mbusy = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R9 reset values
        compare(snap(), {mr[4], mr[3], mr[2], mr[1], mr[0], 1'b0}, "R9 reset");
        rst_n = 1'b1;

        // R1 R4: clear a distinct bit in each bank, bit 31 boundary
        for (int i = 0; i < 5; i++) tick(1'b1, 3'(i), 5'(i * 5 + 2), 1'b0, 1'b0, 1'b0, 1'b0, "R1 R4 clear");
        tick(1'b1, 3'd3, 5'd31, 1'b0, 1'b0, 1'b0, 1'b0, "R4 bit31");
        // R3 set back
        for (int i = 0; i < 5; i++) tick(1'b1, 3'(i), 5'(i * 5 + 2), 1'b1, 1'b0, 1'b0, 1'b0, "R1 R3 set");
        tick(1'b1, 3'd3, 5'd31, 1'b1, 1'b0, 1'b0, 1'b0, "R3 bit31");
        tick(1'b1, 3'd0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 mpu bit0");
        // R2 bad banks
        for (int i = 5; i < 8; i++) tick(1'b1, 3'(i), 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, "R2 bad bank");
        // R8 watchdog
        tick(1'b0, 3'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 release");
        tick(1'b0, 3'd0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R8 hold wins");
        tick(1'b1, 3'd2, 5'(WD), 1'b1, 1'b0, 1'b1, 1'b0, "R8 release over cmd");
        tick(1'b1, 3'd2, 5'(WD), 1'b0, 1'b1, 1'b0, 1'b0, "R8 hold over cmd");
        // prepare group 0 / 1 with released lines
        tick(1'b1, 3'd1, 5'd16, 1'b0, 1'b0, 1'b0, 1'b0, "R4 ecc clear");
        tick(1'b1, 3'd1, 5'd23, 1'b0, 1'b0, 1'b0, 1'b0, "R4 ecc clear");
        tick(1'b1, 3'd1, 5'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R4 p0 clear");
        tick(1'b1, 3'd2, 5'd30, 1'b0, 1'b0, 1'b0, 1'b0, "R4 p1 clear");
        tick(1'b1, 3'd2, 5'(TMR), 1'b1, 1'b0, 1'b0, 1'b0, "R3 tmr set");
        // R5 R6 R10: start with colliding command
        tick(1'b1, 3'd4, 5'd8, 1'b0, 1'b0, 1'b0, 1'b1, "R5 R6 R10 step1");
        // R7 R10: step two with repeated start and strobes
        tick(1'b1, 3'd0, 5'd9, 1'b0, 1'b0, 1'b1, 1'b1, "R7 R10 step2");
        idle("R7 done falls");
        // a second full sequence after release
        tick(1'b1, 3'd1, 5'd20, 1'b0, 1'b0, 1'b0, 1'b0, "R4 ecc clear");
        tick(1'b0, 3'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R6 step1 again");
        idle("R7 step2 again");
        idle("R7 done falls again");
        tick(1'b0, 3'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 release after seq");
        idle("final");
        repeat (3) @(posedge clk);
        #3;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule